// File: doc/BRIEF.md
# BCD Stopwatch with Lap Capture

This block keeps elapsed time in thousandths of a second as three cascaded 4-bit BCD digits. The digits are, from least significant upward, milliseconds, hundredths and tenths. A 1 kHz tick strobe advances the count whenever the watch is running. The watch can be started and stopped by a control write or by a debounced start/stop key. A separate command clears the count. A count of higher seconds is kept outside this block, which only reports the carries out of its upper digits.

Software never reads the live digits directly. It reads a three-digit snapshot buffer one nibble at a time, always in the order milliseconds, hundredths, tenths. Reading the millisecond digit takes a fresh snapshot, unless a lap key press has already frozen one. A lap press loads the buffer and raises a renewal flag. A seconds carry that happens while a lap snapshot is pending raises a second flag, so software can correct the captured time. Four event flags drive one maskable interrupt line: a carry out of the hundredths digit, a carry out of the tenths digit, a start/stop key press and a lap key press.

Top module: `bcd_lap_stopwatch`

## Requirements
- R1: After reset the count is 000, the watch is stopped, the snapshot buffer is 000, and `irq_flags`, `irq`, `renew` and `lap_carry` are all 0.
- R2: While running, each cycle with `tick_ms` high adds one to the count. While stopped, ticks leave the count unchanged.
- R3: The count stays in 000..999 with every digit at most 9. It steps from 999 to 000.
- R4: Flag bit 0 is set on the tick that moves the hundredths digit from 9 to 0, which means the count's last two digits step from 99 to 00.
- R5: Flag bit 1 is set on the tick that moves the count from 999 to 000.
- R6: Flags are set whatever `irq_mask` holds. `irq` is high exactly when some flag bit and the matching mask bit are both 1.
- R7: Writing 1 to a bit of `flag_clr` clears that flag. A set event in the same cycle wins over the clear.
- R8: A `cnt_clr` pulse sets the count to 000, and it stays there while stopped. The pulse does not alter the snapshot buffer.
- R9: A read is a one-cycle `rd_en` with `rd_sel` = 0 (ms), 1 (1/100) or 2 (1/10). `rd_data` is valid from the cycle after the read. With no lap pending, a ms read snapshots the live count, and the following 1/100 and 1/10 reads return that same snapshot.
- R10: A lap key event copies the count into the buffer, sets `renew` and marks a lap pending. A ms read then does not overwrite the buffer. A 1/10 read clears `renew` and the pending mark.
- R11: A key acts on the first `tick_key` sample that sees it high. After that, it acts again only after DEB_SAMPLES consecutive low samples (56 by default). A shorter low run followed by a high sample is ignored. The start/stop key toggles `running` and sets flag bit 2. The lap key sets flag bit 3.
- R12: When both keys are first seen high on the same sample, both take effect: `running` toggles, the buffer captures, and flag bits 2 and 3 are set together.
- R13: A 999-to-000 step while a lap is pending, or in the same cycle as a lap event, sets `lap_carry`. A 1/10 read clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_ms | input | 1 | 1 kHz count strobe |
| tick_key | input | 1 | 1024 Hz key sampling strobe |
| run_wr | input | 1 | Write strobe for the run state |
| run_wdata | input | 1 | Run state to write (1 = run) |
| cnt_clr | input | 1 | Clear the count to 000 |
| key_run | input | 1 | Raw start/stop key, high when pressed |
| key_lap | input | 1 | Raw lap key, high when pressed |
| rd_en | input | 1 | Digit read strobe |
| rd_sel | input | 2 | Digit to read: 0 ms, 1 hundredths, 2 tenths |
| rd_data | output | 4 | BCD digit from the last read |
| flag_clr | input | 4 | Write-one-to-clear for the event flags |
| irq_mask | input | 4 | Interrupt enable per flag |
| irq_flags | output | 4 | Event flags: 0 hundredths carry, 1 tenths carry, 2 start/stop key, 3 lap key |
| irq | output | 1 | Masked OR of the flags |
| running | output | 1 | Run state |
| renew | output | 1 | Buffer refreshed by a lap capture |
| lap_carry | output | 1 | Seconds carry while a lap was pending |

## Verification
The hardest condition to reach is a seconds carry that lands while a lap snapshot is still pending. Reaching it takes the count near 999, then a lap key event that passes the debounce filter, then more ticks before the tenths read. The bench clears the count, ticks it to 995, captures a lap, and ticks past the wrap. It then checks that the snapshot read back still shows 995. The debounce filter is exercised with held keys, a low run shorter than the release window that ends in a bounce, and a full release window followed by a new press. Long random runs of ticks check the BCD count and carry flags against a model held as a binary integer.

// File: rtl/sw_pkg.sv
`timescale 1ns/1ps
package sw_pkg;
   localparam int DIGITS  = 3;
   localparam int DIG_W   = 4;
   localparam int FLAG_W  = 4;
   localparam int NKEYS   = 2;
   localparam int F_HUND  = 0;
   localparam int F_SEC   = 1;
   localparam int F_RKEY  = 2;
   localparam int F_LKEY  = 3;
   localparam int K_RUN   = 0;
   localparam int K_LAP   = 1;

   typedef enum logic [1:0] {
      KS_IDLE = 2'd0,
      KS_HELD = 2'd1,
      KS_REL  = 2'd2
   } key_state_t;
endpackage

// File: rtl/sw_bcd_digit.sv
`timescale 1ns/1ps
module sw_bcd_digit #(
   parameter int W   = 4,
   parameter int TOP = 9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] q,
   output logic         co
);
   localparam logic [W-1:0] LAST = W'(TOP);

   if (TOP >= (1 << W)) begin : g_bad_top
      $error("digit limit does not fit the digit width");
   end

   assign co = inc & (q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (clr)   q <= '0;
      else if (inc)   q <= (q == LAST) ? '0 : q + 1'b1;
   end

   a_r3_digit_range: assert property (@(posedge clk) disable iff (!rst_n)
      q <= LAST);
endmodule

// File: rtl/sw_key_filter.sv
`timescale 1ns/1ps
module sw_key_filter
   import sw_pkg::*;
#(
   parameter int DEB_SAMPLES = 56
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe,
   input  logic key,
   output logic evt
);
   localparam int CW = $clog2(DEB_SAMPLES + 1);
   localparam logic [CW-1:0] LAST_LOW = CW'(DEB_SAMPLES - 1);

   if (DEB_SAMPLES < 2) begin : g_bad_deb
      $error("release window must be at least two samples");
   end

   key_state_t     st;
   logic [CW-1:0]  lows;

   assign evt = strobe & key & (st == KS_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= KS_IDLE;
         lows <= '0;
      end else if (strobe) begin
         unique case (st)
            KS_IDLE: if (key) st <= KS_HELD;
            KS_HELD: if (!key) begin
               st   <= KS_REL;
               lows <= CW'(1);
            end
            KS_REL: begin
               if (key)                  st   <= KS_HELD;
               else if (lows == LAST_LOW) st  <= KS_IDLE;
               else                      lows <= lows + 1'b1;
            end
            default: st <= KS_IDLE;
         endcase
      end
   end

   a_r11_one_event: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> !evt);
endmodule

// File: rtl/bcd_lap_stopwatch.sv
`timescale 1ns/1ps
module bcd_lap_stopwatch
   import sw_pkg::*;
#(
   parameter int DEB_SAMPLES = 56
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        tick_ms,
   input  logic        tick_key,
   input  logic        run_wr,
   input  logic        run_wdata,
   input  logic        cnt_clr,
   input  logic        key_run,
   input  logic        key_lap,
   input  logic        rd_en,
   input  logic [1:0]  rd_sel,
   output logic [3:0]  rd_data,
   input  logic [3:0]  flag_clr,
   input  logic [3:0]  irq_mask,
   output logic [3:0]  irq_flags,
   output logic        irq,
   output logic        running,
   output logic        renew,
   output logic        lap_carry
);
   logic [DIGITS-1:0][DIG_W-1:0] dig;
   logic [DIGITS-1:0][DIG_W-1:0] snap;
   logic [DIGITS:0]              inc_chain;
   logic [DIGITS-1:0]            co;
   logic [NKEYS-1:0]             key_raw, key_evt;
   logic                         hold;
   logic                         rd_first, rd_last;
   logic [FLAG_W-1:0]            flag_set;

   assign inc_chain[0] = running & tick_ms & ~cnt_clr;

   for (genvar i = 0; i < DIGITS; i++) begin : g_dig
      sw_bcd_digit #(.W(DIG_W), .TOP(9)) u_dig (
         .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(inc_chain[i]),
         .q(dig[i]), .co(co[i]));
      assign inc_chain[i+1] = co[i];
   end

   assign key_raw[K_RUN] = key_run;
   assign key_raw[K_LAP] = key_lap;
   for (genvar k = 0; k < NKEYS; k++) begin : g_key
      sw_key_filter #(.DEB_SAMPLES(DEB_SAMPLES)) u_key (
         .clk(clk), .rst_n(rst_n), .strobe(tick_key), .key(key_raw[k]),
         .evt(key_evt[k]));
   end

   assign rd_first = rd_en & (rd_sel == 2'd0);
   assign rd_last  = rd_en & (rd_sel == 2'd2);

   always_comb begin
      flag_set         = '0;
      flag_set[F_HUND] = co[1];
      flag_set[F_SEC]  = co[DIGITS-1];
      flag_set[F_RKEY] = key_evt[K_RUN];
      flag_set[F_LKEY] = key_evt[K_LAP];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running   <= 1'b0;
         snap      <= '0;
         hold      <= 1'b0;
         renew     <= 1'b0;
         lap_carry <= 1'b0;
         rd_data   <= '0;
         irq_flags <= '0;
      end else begin
         if (run_wr)              running <= run_wdata;
         else if (key_evt[K_RUN]) running <= ~running;

         if (key_evt[K_LAP] || (rd_first && !hold)) snap <= dig;

         if (rd_en) begin
            unique case (rd_sel)
               2'd0:    rd_data <= hold ? snap[0] : dig[0];
               2'd1:    rd_data <= snap[1];
               2'd2:    rd_data <= snap[2];
               default: rd_data <= '0;
            endcase
         end

         if (key_evt[K_LAP]) begin
            hold  <= 1'b1;
            renew <= 1'b1;
         end else if (rd_last) begin
            hold  <= 1'b0;
            renew <= 1'b0;
         end

         if (co[DIGITS-1] && (hold || key_evt[K_LAP])) lap_carry <= 1'b1;
         else if (rd_last)                              lap_carry <= 1'b0;

         irq_flags <= (irq_flags & ~flag_clr) | flag_set;
      end
   end

   assign irq = |(irq_flags & irq_mask);

   a_r2_stopped_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!running && !cnt_clr) |=> $stable(dig));
   a_r5_wrap_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (running && tick_ms && !cnt_clr && dig == {4'd9, 4'd9, 4'd9})
         |=> (irq_flags[F_SEC] && dig == '0));
   a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_clr |=> (dig == '0));
   a_r10_lap_renew: assert property (@(posedge clk) disable iff (!rst_n)
      key_evt[K_LAP] |=> (renew && snap == $past(dig)));
   a_r8_snap_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_clr && !key_evt[K_LAP] && !rd_first) |=> $stable(snap));
endmodule

// File: tb/sim_bcd_lap_stopwatch.sv
`timescale 1ns/1ps
module sim_bcd_lap_stopwatch;
   localparam int DEB = 56;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick_ms = 0, tick_key = 0, run_wr = 0, run_wdata = 0, cnt_clr = 0;
   logic key_run = 0, key_lap = 0, rd_en = 0;
   logic [1:0] rd_sel = '0;
   logic [3:0] flag_clr = '0, irq_mask = '0;
   logic [3:0] rd_data, irq_flags;
   logic irq, running, renew, lap_carry;

   int checks = 0, errors = 0;
   int m_cnt = 0;
   bit m_run = 0;
   bit m_hold = 0;
   bit [3:0] m_flags = '0;
   bit m_lcar = 0;

   always #2.5 clk = ~clk;

   bcd_lap_stopwatch #(.DEB_SAMPLES(DEB)) u0 (
      .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .tick_key(tick_key),
      .run_wr(run_wr), .run_wdata(run_wdata), .cnt_clr(cnt_clr),
      .key_run(key_run), .key_lap(key_lap), .rd_en(rd_en), .rd_sel(rd_sel),
      .rd_data(rd_data), .flag_clr(flag_clr), .irq_mask(irq_mask),
      .irq_flags(irq_flags), .irq(irq), .running(running), .renew(renew),
      .lap_carry(lap_carry));

   function automatic int next_count(int c);
      return (c + 1) % 1000;
   endfunction

   function automatic bit masked_irq(bit [3:0] f, bit [3:0] m);
      return |(f & m);
   endfunction

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic ticks(int n);
      for (int i = 0; i < n; i++) begin
         tick_ms = 1'b1;
         @(negedge clk);
         if (m_run) begin
            m_cnt = next_count(m_cnt);
            if (m_cnt % 100 == 0) m_flags[0] = 1'b1;
            if (m_cnt == 0) begin
               m_flags[1] = 1'b1;
               if (m_hold) m_lcar = 1'b1;
            end
         end
      end
      tick_ms = 1'b0;
   endtask

   task automatic read_time(output int value);
      int d0, d1, d2;
      rd_en = 1'b1; rd_sel = 2'd0; @(negedge clk); d0 = rd_data;
      rd_sel = 2'd1; @(negedge clk); d1 = rd_data;
      rd_sel = 2'd2; @(negedge clk); d2 = rd_data;
      rd_en = 1'b0; rd_sel = 2'd0;
      m_hold = 0; m_lcar = 0;
      value = (d0 > 9 || d1 > 9 || d2 > 9) ? -1 : d2 * 100 + d1 * 10 + d0;
   endtask

   task automatic clear_flags(logic [3:0] b);
      flag_clr = b; @(negedge clk); flag_clr = '0;
      m_flags = m_flags & ~b;
   endtask

   task automatic clear_count();
      cnt_clr = 1'b1; @(negedge clk); cnt_clr = 1'b0;
      m_cnt = 0;
   endtask

   task automatic set_run(bit v);
      run_wr = 1'b1; run_wdata = v; @(negedge clk); run_wr = 1'b0;
      m_run = v;
   endtask

   task automatic key_samp(bit r, bit l);
      key_run = r; key_lap = l; tick_key = 1'b1;
      @(negedge clk); tick_key = 1'b0; @(negedge clk);
   endtask

   task automatic release_keys();
      for (int i = 0; i < DEB; i++) key_samp(0, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int v, lapv;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 flags", irq_flags, 0);
      check("R1 irq", irq, 0);
      check("R1 running", running, 0);
      check("R1 renew", renew, 0);
      check("R1 lap_carry", lap_carry, 0);
      read_time(v); check("R1 count", v, 0);

      // R2 stopped ignores ticks
      ticks(5); read_time(v); check("R2 stopped", v, 0);
      set_run(1); check("R2 running", running, 1);
      ticks(7); read_time(v); check("R2 count", v, 7);

      // R2 R3 random runs
      for (int it = 0; it < 20; it++) begin
         ticks($urandom_range(1, 400));
         read_time(v); check("R3 random count", v, m_cnt);
         check("R4 R5 random flags", irq_flags[1:0], m_flags[1:0]);
         clear_flags(4'b0011);
      end

      // R4 hundredths carry
      clear_count(); clear_flags(4'hF);
      ticks(99); check("R4 no carry yet", irq_flags[0], 0);
      ticks(1);  check("R4 carry flag", irq_flags[0], 1);
      read_time(v); check("R4 count", v, 100);
      // R5 wrap
      ticks(899); read_time(v); check("R3 max count", v, 999);
      check("R5 no wrap yet", irq_flags[1], 0);
      ticks(1); check("R5 wrap flag", irq_flags[1], 1);
      read_time(v); check("R3 wrap to zero", v, 0);

      // R6 masking
      irq_mask = 4'b0000; @(negedge clk); check("R6 masked", irq, 0);
      irq_mask = 4'b0010; @(negedge clk); check("R6 enabled", irq, 1);
      irq_mask = 4'b1100; @(negedge clk);
      check("R6 other bits", irq, masked_irq(m_flags, 4'b1100));
      irq_mask = 4'b0000;

      // R7 clear and set-wins
      clear_flags(4'b0001);
      check("R7 clear bit0", irq_flags[0], 0);
      check("R7 bit1 kept", irq_flags[1], 1);
      clear_flags(4'hF); clear_count(); ticks(99);
      tick_ms = 1'b1; flag_clr = 4'b0001; @(negedge clk);
      tick_ms = 1'b0; flag_clr = '0; m_cnt = 100;
      check("R7 set wins", irq_flags[0], 1);
      clear_flags(4'hF);

      // R11 debounce on the start/stop key
      key_samp(1, 0); m_run = !m_run;
      check("R11 press toggles", running, m_run);
      check("R11 press flag", irq_flags[2], 1);
      clear_flags(4'b0100);
      key_samp(1, 0); key_samp(1, 0);
      check("R11 held no repeat", irq_flags[2], 0);
      for (int i = 0; i < 10; i++) key_samp(0, 0);
      key_samp(1, 0);
      check("R11 bounce ignored flag", irq_flags[2], 0);
      check("R11 bounce ignored run", running, m_run);
      release_keys();
      key_samp(1, 0); m_run = !m_run;
      check("R11 press after release", irq_flags[2], 1);
      check("R11 run toggled again", running, m_run);
      release_keys();
      if (!m_run) set_run(1);

      // R10 lap capture
      clear_flags(4'hF); ticks(123);
      lapv = m_cnt;
      key_samp(0, 1); m_hold = 1;
      check("R10 renew set", renew, 1);
      check("R11 lap flag", irq_flags[3], 1);
      ticks(37);
      read_time(v); check("R10 frozen snapshot", v, lapv);
      check("R10 renew cleared", renew, 0);
      read_time(v); check("R9 live snapshot", v, m_cnt);
      release_keys();

      // R13 carry while lap pending
      clear_count(); ticks(995);
      key_samp(0, 1); m_hold = 1;
      ticks(10);
      check("R13 lap carry", lap_carry, 1);
      check("R5 wrap during lap", irq_flags[1], 1);
      read_time(v); check("R13 snapshot kept", v, 995);
      check("R13 lap carry cleared", lap_carry, 0);
      release_keys();

      // R8 clear keeps buffer
      ticks(20); lapv = m_cnt;
      key_samp(0, 1); m_hold = 1;
      set_run(0); clear_count(); ticks(3);
      read_time(v); check("R8 buffer untouched", v, lapv);
      read_time(v); check("R8 count cleared", v, 0);
      release_keys();

      // R12 simultaneous keys
      clear_flags(4'hF);
      key_samp(1, 1); m_run = !m_run; m_hold = 1;
      check("R12 run toggled", running, m_run);
      check("R12 both flags", irq_flags[3:2], 3);
      check("R12 renew", renew, 1);
      read_time(v); check("R12 captured", v, 0);
      release_keys();

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule